// File: doc/BRIEF.md
# Low-Transition Scan Pattern Generator

This block is a pseudorandom pattern source for logic self-test in which each pattern is one full load of a scan chain. A maximal-length Fibonacci shift register produces pseudorandom bits. An AND gate watches K selected register stages. Its output drives the toggle input of a single flip-flop, and that flip-flop's output is the serial bit stream fed into the scan chain.

The flip-flop changes value only on a cycle when every watched stage is one. That happens on roughly one cycle in 2^K. Adjacent scan bits are therefore strongly correlated, and the chain sees far fewer transitions while it shifts. This lowers switching activity during test. K and the watched stages are parameters, so the balance between fewer transitions and fault coverage can be set for each circuit.

A shift counter sized to the chain length L marks the last bit of every pattern. A seed port restarts the sequence from a chosen state.

Top module: `ltscan_gen`

## Requirements
- R1: While reset is held, and until the first enabled shift after it, scan_in is 0 and pattern_done is 0. Reset loads the register with the default seed 16'hACE1, clears the toggle flip-flop and clears the shift counter.
- R2: The pseudorandom register is 16 bits wide. On each enabled shift it moves one place toward the MSB, and the new bit 0 is the XOR of bits 15, 14, 12 and 3 taken from before the shift.
- R3: After an enabled shift, scan_in is inverted if stages 15, 9 and 2 of the register were all 1 before the shift (the default K=3). Otherwise scan_in keeps its value.
- R4: When shift_en is low and seed_load is low, the register, scan_in and the shift counter all keep their state.
- R5: A seed_load cycle acts whether or not shift_en is high. It loads seed_value into the register, clears scan_in to 0 and clears the shift counter. A seed_value of zero is replaced by 16'hACE1.
- R6: The counter counts enabled shifts from 0 to L-1 and then wraps to 0 (default L=32). pattern_done is high in exactly those cycles where shift_en is high, seed_load is low and the counter is at L-1, which is the cycle whose scan_in bit completes the pattern.
- R7: Over a long enabled run, scan_in has fewer transitions than bit 0 of the same pseudorandom register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| shift_en | input | 1 | Advances the generator and the shift counter by one bit |
| seed_load | input | 1 | Loads seed_value and restarts the pattern |
| seed_value | input | 16 | Seed for the pseudorandom register (0 selects the default) |
| scan_in | output | 1 | Serial scan data (toggle flip-flop output) |
| pattern_done | output | 1 | High in the cycle that carries the last bit of a pattern |

## Verification
scan_in is a register output. After each enabled edge it shows the toggle decision made from the register stages held before that edge. pattern_done is combinational, so it is due in the same cycle as the shift_en that completes the pattern. The bench keeps a cycle-accurate model that it steps in the same cycle it drives inputs. Each step pushes the values the ports must show in that cycle into a queue, and a monitor pops and compares them well after the falling edge. Reset release passes through two synchronizing flops, so the bench waits idle cycles before the first enabled shift.

// File: rtl/ltscan_pkg.sv
package ltscan_pkg;
  localparam int unsigned   LTS_W_DEF    = 16;
  localparam logic [15:0]   LTS_POLY_DEF = 16'hD008; // stages 15,14,12,3
  localparam logic [15:0]   LTS_SEED_DEF = 16'hACE1;
  localparam int unsigned   LTS_IDX_W    = 8;        // width of one AND-tap index field
endpackage

// File: rtl/ltscan_lfsr.sv
module ltscan_lfsr #(
  parameter int unsigned W    = 16,
  parameter logic [W-1:0] POLY = '1,
  parameter logic [W-1:0] SEED = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         load,
  input  logic [W-1:0] seed_val,
  output logic [W-1:0] state
);
  logic [W-1:0] state_q, state_d;
  logic         fb;

  always_comb begin
    fb = ^(state_q & POLY);
    if (load)
      state_d = (seed_val == '0) ? SEED : seed_val;
    else if (en)
      state_d = {state_q[W-2:0], fb};
    else
      state_d = state_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SEED;
    else        state_q <= state_d;
  end

  assign state = state_q;

  AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    state_q != '0); // R2
  AST_LFSR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !load) |=> $stable(state_q)); // R4
  AST_LFSR_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !load) |=> state_q[W-1:1] == $past(state_q[W-2:0])); // R2
endmodule

// File: rtl/ltscan_toggle.sv
module ltscan_toggle #(
  parameter int unsigned W   = 16,
  parameter int unsigned K   = 3,
  parameter int unsigned IW  = 8,
  parameter logic [K*IW-1:0] SEL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         clr,
  input  logic [W-1:0] state,
  output logic         q
);
  logic [K-1:0] picked;
  logic         trig;
  logic         q_q, q_d;

  for (genvar i = 0; i < K; i++) begin : g_tap
    localparam int unsigned IDX = int'(SEL[i*IW +: IW]);
    assign picked[i] = state[IDX];
  end

  assign trig = &picked;

  always_comb begin
    if (clr)
      q_d = 1'b0;
    else if (en && trig)
      q_d = ~q_q;
    else
      q_d = q_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_q <= 1'b0;
    else        q_q <= q_d;
  end

  assign q = q_q;

  AST_TOGGLE_ON_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
    (en && trig && !clr) |=> (q_q != $past(q_q))); // R3
  AST_HOLD_NO_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
    (!(en && trig) && !clr) |=> $stable(q_q)); // R3
  AST_CLEAR_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !q_q); // R5
endmodule

// File: rtl/ltscan_count.sv
module ltscan_count #(
  parameter int unsigned L = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic clr,
  output logic last
);
  localparam int unsigned CW = (L > 1) ? $clog2(L) : 1;
  localparam logic [CW-1:0] TOP = CW'(L - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  assign last = (cnt_q == TOP);

  always_comb begin
    if (clr)
      cnt_d = '0;
    else if (en)
      cnt_d = last ? '0 : cnt_q + CW'(1);
    else
      cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= TOP); // R6
  AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0)); // R5
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !clr) |=> $stable(cnt_q)); // R4
endmodule

// File: rtl/ltscan_gen.sv
module ltscan_gen #(
  parameter int unsigned  W    = ltscan_pkg::LTS_W_DEF,
  parameter logic [W-1:0] POLY = ltscan_pkg::LTS_POLY_DEF,
  parameter logic [W-1:0] SEED = ltscan_pkg::LTS_SEED_DEF,
  parameter int unsigned  K    = 3,
  parameter logic [K*ltscan_pkg::LTS_IDX_W-1:0] SEL = {8'd15, 8'd9, 8'd2},
  parameter int unsigned  L    = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_en,
  input  logic         seed_load,
  input  logic [W-1:0] seed_value,
  output logic         scan_in,
  output logic         pattern_done
);
  logic [1:0]   rst_sync_q;
  logic         core_rst_n;
  logic [W-1:0] lfsr_state;
  logic         last_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign core_rst_n = rst_sync_q[1];

  ltscan_lfsr #(.W(W), .POLY(POLY), .SEED(SEED)) u_lfsr (
    .clk      (clk),
    .rst_n    (core_rst_n),
    .en       (shift_en),
    .load     (seed_load),
    .seed_val (seed_value),
    .state    (lfsr_state)
  );

  ltscan_toggle #(.W(W), .K(K), .IW(ltscan_pkg::LTS_IDX_W), .SEL(SEL)) u_toggle (
    .clk   (clk),
    .rst_n (core_rst_n),
    .en    (shift_en),
    .clr   (seed_load),
    .state (lfsr_state),
    .q     (scan_in)
  );

  ltscan_count #(.L(L)) u_count (
    .clk   (clk),
    .rst_n (core_rst_n),
    .en    (shift_en),
    .clr   (seed_load),
    .last  (last_bit)
  );

  assign pattern_done = shift_en & ~seed_load & last_bit;

  AST_DONE_NEEDS_SHIFT: assert property (@(posedge clk) disable iff (!core_rst_n)
    pattern_done |-> (shift_en && !seed_load)); // R6
endmodule

// File: tb/ltscan_gen_bench.sv
module ltscan_gen_bench;
  localparam int L = 32;
  localparam logic [15:0] DFLT = 16'hACE1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        shift_en = 1'b0;
  logic        seed_load = 1'b0;
  logic [15:0] seed_value = '0;
  logic        scan_in;
  logic        pattern_done;

  int checks = 0;
  int errors = 0;

  bit    exp_scan_q[$];
  bit    exp_done_q[$];
  string tag_q[$];

  logic [15:0] m_s = DFLT;
  bit          m_t = 1'b0;
  int          m_c = 0;

  bit count_on = 1'b0;
  bit prev_scan = 1'b0;
  int dut_tog = 0;
  int plain_tog = 0;

  always #5 clk = ~clk;

  ltscan_gen u_ltscan_gen (
    .clk          (clk),
    .rst_n        (rst_n),
    .shift_en     (shift_en),
    .seed_load    (seed_load),
    .seed_value   (seed_value),
    .scan_in      (scan_in),
    .pattern_done (pattern_done)
  );

  task automatic chk(input string tag, input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0b expected %0b at %0t", tag, what, act, exp, $time);
    end
  endtask

  // driver: drives one cycle, pushes what the ports must show, steps the model
  task automatic step(input bit en, input bit ld, input logic [15:0] sd, input string tag);
    bit fb, trig, old0;
    @(negedge clk);
    shift_en   = en;
    seed_load  = ld;
    seed_value = sd;
    exp_scan_q.push_back(m_t);
    exp_done_q.push_back(en && !ld && (m_c == L - 1));
    tag_q.push_back(tag);
    old0 = m_s[0];
    if (ld) begin
      m_s = (sd == 16'h0) ? DFLT : sd;
      m_t = 1'b0;
      m_c = 0;
    end else if (en) begin
      trig = m_s[15] & m_s[9] & m_s[2];
      fb   = m_s[15] ^ m_s[14] ^ m_s[12] ^ m_s[3];
      m_t  = m_t ^ trig;
      m_s  = {m_s[14:0], fb};
      m_c  = (m_c == L - 1) ? 0 : m_c + 1;
      if (count_on && (m_s[0] != old0)) plain_tog++;
    end
  endtask

  // monitor: compares after the inputs for the cycle have settled
  always @(negedge clk) begin
    #2;
    while (exp_scan_q.size() > 0) begin
      string t;
      bit es, ed;
      es = exp_scan_q.pop_front();
      ed = exp_done_q.pop_front();
      t  = tag_q.pop_front();
      chk(t, scan_in, es, "scan_in");
      chk(t, pattern_done, ed, "pattern_done");
    end
    if (count_on && (scan_in != prev_scan)) dut_tog++;
    prev_scan = scan_in;
  end

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    #2;
    chk("R1", scan_in, 1'b0, "scan_in in reset");
    chk("R1", pattern_done, 1'b0, "pattern_done in reset");
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) step(0, 0, 16'h0, "R1");

    // R2 R3 R6: free run from default seed, several patterns
    for (int i = 0; i < 8 * L; i++) step(1, 0, 16'h0, "R2_R3_R6");

    // R4: gapped enable, then a long hold
    for (int i = 0; i < 120; i++) step((i % 3) != 0, 0, 16'h0, "R4");
    for (int i = 0; i < 25; i++) step(0, 0, 16'hFFFF, "R4");
    for (int i = 0; i < 2 * L; i++) step(1, 0, 16'h0, "R4");

    // R5: user seed with shift_en high
    step(1, 1, 16'h1234, "R5");
    for (int i = 0; i < 3 * L; i++) step(1, 0, 16'h0, "R5");
    // R5: load mid-pattern with shift_en low
    for (int i = 0; i < 7; i++) step(1, 0, 16'h0, "R5");
    step(0, 1, 16'hFFFF, "R5");
    for (int i = 0; i < 3 * L; i++) step(1, 0, 16'h0, "R5");
    // R5: zero seed selects the default
    step(1, 1, 16'h0000, "R5");
    for (int i = 0; i < 4 * L; i++) step(1, 0, 16'h0, "R5");

    // R6: done on the wrap with enable gaps near the boundary
    for (int i = 0; i < 4 * L; i++) step((i % 5) != 2, 0, 16'h0, "R6");

    // R7: transition rate over a long run
    step(1, 1, 16'hBEEF, "R7");
    @(negedge clk);
    #3;
    prev_scan = scan_in;
    count_on  = 1'b1;
    for (int i = 0; i < 4000; i++) step(1, 0, 16'h0, "R7");
    @(negedge clk);
    #3;
    count_on = 1'b0;
    checks++;
    if (!(dut_tog < plain_tog) || plain_tog == 0) begin
      errors++;
      $display("FAIL R7 toggle rate: actual %0d scan_in transitions expected fewer than %0d", dut_tog, plain_tog);
    end
    checks++;
    if (dut_tog > 1000) begin
      errors++;
      $display("FAIL R7 toggle rate: actual %0d transitions expected at most 1000", dut_tog);
    end

    step(0, 0, 16'h0, "R4");
    @(negedge clk);
    #4;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule